// File: doc/BRIEF.md
# Buffered Serial Input Port Deserializer

This block captures a narrow input pin bus (1 bit or 4 bits wide, fixed by a parameter) on every rising edge of the port clock while the port is enabled. It packs successive samples into an assembly register until a word of the selected transfer width is complete. On that same edge the word moves into a separate holding register, and the assembly register starts on the next word immediately. The assembly side never pauses. After a word completes, a slow reader has one full word period to collect it.

The reader takes words through a valid/ready stream. `rd_valid` stays low until a complete word is held, so a reader waiting on `rd_ready` is stalled. A transfer happens on any edge where both signals are high, and the holding register is then freed. Back-pressure does not reach the pins. If the reader holds `rd_ready` low past the next completion, the held word is replaced and a sticky overrun flag is raised. The transfer width is loaded through a strobe. Only widths from 1 to 32 that are a multiple of the pin width are taken; any other value is dropped.

Top module: `pin_deserializer`

## Requirements
- R1: After reset, `rd_valid` and `overrun` are 0, and the transfer width equals the pin width PIN_W.
- R2: Each enabled edge captures `pin_in`. The first sample of a word goes into bits [PIN_W-1:0], and each later sample goes into the next PIN_W bits above it. Bits above the transfer width read as 0.
- R3: A word completes on the edge that captures its (width/PIN_W)-th sample. `rd_valid` is high with that word in the cycle after that edge.
- R4: `rd_valid` stays low until a complete word is held. While `rd_valid` is high and `rd_ready` is low, `rd_data` holds steady until the next word completes.
- R5: An edge where `rd_valid` and `rd_ready` are both high consumes the word, and `rd_valid` is 0 afterwards. If a new word completes on that same edge, the new word is presented and no overrun is flagged.
- R6: If a word completes while `rd_valid` is high and `rd_ready` is low, the new word replaces the held one and `overrun` becomes 1.
- R7: `overrun` is sticky. It is cleared by `ovr_clr`, and a new overrun on the same edge takes priority over the clear.
- R8: An edge with `enable` low clears the partial word, the sample count, `rd_valid` and `overrun`. The first enabled edge afterwards starts a new word.
- R9: `cfg_load` with a legal `cfg_width` (1 to 32, a multiple of PIN_W) sets the width and clears the partial word and `rd_valid`. The sample present on that edge is discarded.
- R10: `cfg_load` with an illegal `cfg_width` has no effect: the width, the partial word and the held word are all kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Port capture enable; low clears the port state |
| pin_in | input | PIN_W | Sampled pin bus |
| cfg_load | input | 1 | Strobe to load a new transfer width |
| cfg_width | input | 6 | Requested transfer width in bits |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| rd_valid | output | 1 | Holding register contains an unread word |
| rd_ready | input | 1 | Reader accepts the word on this edge |
| rd_data | output | 32 | Held word, with the first sample in the least significant bits |
| overrun | output | 1 | Sticky flag: an unread word was overwritten |

## Verification
A wrong sample counter shows up in the first word as `rd_valid` rising one or more cycles early or late, or as nibbles landing in the wrong positions of `rd_data`. A holding register that fails to release, or that overwrites without flagging, shows within two word periods: either `overrun` is missing when a read was skipped, or it appears during back-to-back reads at a width equal to the pin width. A width update that leaks into the state shows as a word that is misaligned or completes at the wrong time. Depending on the case, this is either a legal load that keeps the partial word, or an illegal load that changes the word length.

// File: rtl/pin_deserializer_pkg.sv
package pin_deserializer_pkg;
  localparam int XFER_MAX = 32;
  localparam int CFG_W    = 6;
  typedef logic [XFER_MAX-1:0] word_t;
  typedef logic [CFG_W-1:0]    width_t;

  // A width is usable when it fits the word and is a whole number of pin samples.
  function automatic logic width_ok(input width_t w, input int pin_w);
    int wi;
    wi = int'(w);
    return (wi >= pin_w) && (wi <= XFER_MAX) && ((wi % pin_w) == 0);
  endfunction
endpackage

// File: rtl/pin_deserializer_width.sv
module pin_deserializer_width
  import pin_deserializer_pkg::*;
#(
  parameter int PIN_W = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cfg_load,
  input  width_t cfg_width,
  output width_t width_q,
  output logic   cfg_accept
);
  localparam width_t RESET_WIDTH = width_t'(PIN_W);

  assign cfg_accept = cfg_load && width_ok(cfg_width, PIN_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      width_q <= RESET_WIDTH;
    end else if (cfg_accept) begin
      width_q <= cfg_width;
    end
  end
endmodule

// File: rtl/pin_deserializer_shift.sv
module pin_deserializer_shift
  import pin_deserializer_pkg::*;
#(
  parameter int PIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             restart,
  input  logic [PIN_W-1:0] pin_in,
  input  width_t           width_q,
  output logic             word_done,
  output word_t            word
);
  localparam int SH = $clog2(PIN_W);

  width_t cnt_q;
  width_t samples_per_word;
  width_t pos;
  word_t  shift_q;
  word_t  sample_ext;
  word_t  merged;

  assign samples_per_word = width_q >> SH;
  assign pos              = cnt_q << SH;
  assign sample_ext       = word_t'(pin_in) << pos;
  assign merged           = shift_q | sample_ext;
  assign word_done        = enable && !restart && (cnt_q == samples_per_word - width_t'(1));
  assign word             = merged;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt_q   <= '0;
      shift_q <= '0;
    end else if (enable) begin
      if (word_done) begin
        cnt_q   <= '0;
        shift_q <= '0;
      end else begin
        cnt_q   <= cnt_q + width_t'(1);
        shift_q <= merged;
      end
    end
  end
endmodule

// File: rtl/pin_deserializer_hold.sv
module pin_deserializer_hold
  import pin_deserializer_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  enable,
  input  logic  restart,
  input  logic  word_done,
  input  word_t word,
  input  logic  rd_ready,
  input  logic  ovr_clr,
  output logic  rd_valid,
  output word_t rd_data,
  output logic  overrun
);
  logic lost;

  assign lost = word_done && rd_valid && !rd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      rd_valid <= 1'b0;
    end else if (word_done) begin
      rd_valid <= 1'b1;
    end else if (rd_valid && rd_ready) begin
      rd_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (word_done) begin
      rd_data <= word;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      overrun <= 1'b0;
    end else if (lost) begin
      overrun <= 1'b1;
    end else if (ovr_clr) begin
      overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/pin_deserializer.sv
module pin_deserializer
  import pin_deserializer_pkg::*;
#(
  parameter int PIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PIN_W-1:0] pin_in,
  input  logic             cfg_load,
  input  logic [5:0]       cfg_width,
  input  logic             ovr_clr,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [31:0]      rd_data,
  output logic             overrun
);
  width_t width_q;
  logic   cfg_accept;
  logic   restart;
  logic   word_done;
  word_t  word;

  assign restart = cfg_accept || !enable;

  pin_deserializer_width #(.PIN_W(PIN_W)) u_width (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_width(cfg_width),
    .width_q(width_q), .cfg_accept(cfg_accept)
  );

  pin_deserializer_shift #(.PIN_W(PIN_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .enable(enable), .restart(restart), .pin_in(pin_in),
    .width_q(width_q), .word_done(word_done), .word(word)
  );

  pin_deserializer_hold u_hold (
    .clk(clk), .rst_n(rst_n), .enable(enable), .restart(restart),
    .word_done(word_done), .word(word), .rd_ready(rd_ready), .ovr_clr(ovr_clr),
    .rd_valid(rd_valid), .rd_data(rd_data), .overrun(overrun)
  );
endmodule

// File: rtl/pin_deserializer_chk.sv
module pin_deserializer_chk #(
  parameter int PIN_W = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        enable,
  input logic        cfg_accept,
  input logic        word_done,
  input logic [5:0]  width_q,
  input logic        ovr_clr,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [31:0] rd_data,
  input logic        overrun
);
  // R4
  hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !word_done && enable && !cfg_accept) |=> (rd_valid && $stable(rd_data)));

  // R6
  overwrite_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && rd_valid && !rd_ready) |=> overrun);

  // R5
  consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && !word_done) |=> !rd_valid);

  // R5
  no_false_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!overrun && !(word_done && rd_valid && !rd_ready)) |=> !overrun);

  // R8
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!rd_valid && !overrun));

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && enable && !ovr_clr) |=> overrun);

  // R9
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_accept |=> !rd_valid);

  // R10
  always_ff @(posedge clk) begin
    if (rst_n) begin
      width_legal_chk: assert ((width_q != 6'd0) && (width_q <= 6'd32) && ((int'(width_q) % PIN_W) == 0));
    end
  end
endmodule

bind pin_deserializer pin_deserializer_chk #(.PIN_W(PIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_accept(cfg_accept),
  .word_done(word_done), .width_q(width_q), .ovr_clr(ovr_clr),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .overrun(overrun)
);

// File: tb/sim_pin_deserializer.sv
`timescale 1ns/1ps
module sim_pin_deserializer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [3:0]  pin_in = '0;
  logic        cfg_load = 1'b0;
  logic [5:0]  cfg_width = '0;
  logic        ovr_clr = 1'b0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [31:0] rd_data;
  logic        overrun;
  int          n_chk = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  pin_deserializer #(.PIN_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pin_in(pin_in), .cfg_load(cfg_load),
    .cfg_width(cfg_width), .ovr_clr(ovr_clr), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .overrun(overrun)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_width(input logic [5:0] w);
    enable = 1'b0; cfg_load = 1'b1; cfg_width = w; cyc();
    cfg_load = 1'b0;
  endtask

  task automatic feed(input logic [3:0] n, input logic rdy);
    enable = 1'b1; pin_in = n; rd_ready = rdy; cyc();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cyc(); cyc();
    chk("R1 valid", {31'b0, rd_valid}, 32'd0);
    chk("R1 overrun", {31'b0, overrun}, 32'd0);
    rst_n = 1'b1;
    feed(4'h5, 1'b0);
    chk("R1 default width valid", {31'b0, rd_valid}, 32'd1);
    chk("R1 default width data", rd_data, 32'h5);
    enable = 1'b0; cyc();
  endtask

  task automatic t_width8();
    set_width(6'd8);
    feed(4'h3, 1'b0);
    chk("R4 stall", {31'b0, rd_valid}, 32'd0);
    feed(4'hA, 1'b0);
    chk("R3 valid", {31'b0, rd_valid}, 32'd1);
    chk("R2 order", rd_data, 32'h0000_00A3);
    enable = 1'b0; cyc();
  endtask

  task automatic t_width32_slack();
    set_width(6'd32);
    for (int i = 0; i < 8; i++) begin
      feed(4'(i + 1), 1'b0);
      if (i < 7) chk("R4 stall 32", {31'b0, rd_valid}, 32'd0);
    end
    chk("R3 valid 32", {31'b0, rd_valid}, 32'd1);
    chk("R2 word 32", rd_data, 32'h8765_4321);
    for (int k = 0; k < 6; k++) begin
      feed(4'(k + 9), 1'b0);
      chk("R4 hold data", rd_data, 32'h8765_4321);
    end
    feed(4'hF, 1'b1);
    chk("R5 consumed", {31'b0, rd_valid}, 32'd0);
    feed(4'h0, 1'b0);
    chk("R5 next word", rd_data, 32'h0FED_CBA9);
    chk("R6 no overrun in slack", {31'b0, overrun}, 32'd0);
    enable = 1'b0; rd_ready = 1'b0; cyc();
  endtask

  task automatic t_overrun();
    set_width(6'd8);
    feed(4'h1, 1'b0); feed(4'h2, 1'b0);
    feed(4'h3, 1'b0); feed(4'h4, 1'b0);
    chk("R6 overrun", {31'b0, overrun}, 32'd1);
    chk("R6 replaced", rd_data, 32'h0000_0043);
    feed(4'h5, 1'b1);
    chk("R7 sticky", {31'b0, overrun}, 32'd1);
    ovr_clr = 1'b1; feed(4'h6, 1'b0); ovr_clr = 1'b0;
    chk("R7 cleared", {31'b0, overrun}, 32'd0);
    chk("R7 word", rd_data, 32'h0000_0065);
    feed(4'h7, 1'b0);
    ovr_clr = 1'b1; feed(4'h8, 1'b0); ovr_clr = 1'b0;
    chk("R7 set wins", {31'b0, overrun}, 32'd1);
    enable = 1'b0; cyc();
    chk("R8 overrun cleared", {31'b0, overrun}, 32'd0);
    chk("R8 valid cleared", {31'b0, rd_valid}, 32'd0);
  endtask

  task automatic t_back2back();
    set_width(6'd4);
    feed(4'h0, 1'b1);
    for (int i = 1; i < 16; i++) begin
      feed(4'(i), 1'b1);
      chk("R5 b2b valid", {31'b0, rd_valid}, 32'd1);
      chk("R5 b2b data", rd_data, 32'(i));
      chk("R5 b2b overrun", {31'b0, overrun}, 32'd0);
    end
    enable = 1'b0; rd_ready = 1'b0; cyc();
  endtask

  task automatic t_illegal();
    set_width(6'd8);
    feed(4'h1, 1'b1);
    cfg_load = 1'b1; cfg_width = 6'd6; feed(4'h2, 1'b1);
    chk("R10 width 6 ignored", rd_data, 32'h0000_0021);
    chk("R10 valid", {31'b0, rd_valid}, 32'd1);
    cfg_width = 6'd33; feed(4'h3, 1'b1);
    cfg_width = 6'd0; feed(4'h4, 1'b1);
    cfg_load = 1'b0;
    chk("R10 width 33/0 ignored", rd_data, 32'h0000_0043);
    chk("R10 valid 2", {31'b0, rd_valid}, 32'd1);
    enable = 1'b0; rd_ready = 1'b0; cyc();
  endtask

  task automatic t_restart();
    set_width(6'd8);
    feed(4'h1, 1'b0);
    cfg_load = 1'b1; cfg_width = 6'd8; feed(4'h2, 1'b0); cfg_load = 1'b0;
    feed(4'h3, 1'b0); feed(4'h4, 1'b0);
    chk("R9 realigned", rd_data, 32'h0000_0043);
    cfg_load = 1'b1; feed(4'h5, 1'b0); cfg_load = 1'b0;
    chk("R9 valid cleared", {31'b0, rd_valid}, 32'd0);
    feed(4'h9, 1'b0);
    enable = 1'b0; cyc();
    feed(4'h5, 1'b0); feed(4'h6, 1'b0);
    chk("R8 realigned", rd_data, 32'h0000_0065);
    enable = 1'b0; cyc();
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc();
    t_reset();
    t_width8();
    t_width32_slack();
    t_overrun();
    t_back2back();
    t_illegal();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule